// File: doc/BRIEF.md
# Wide Vector Upper-Half Power-Gate Controller

This controller decides when the upper half of a wide SIMD datapath gets power. At reset the upper half is off. The first wide operation that arrives moves the controller into an emulation mode. In that mode wide operations run on the lower half alone, and the issue logic is told to slow down by a factor of four. A programmable number of wide operations run this way. After that the upper half is powered up, and the whole core is stalled while its supply settles. Every hardware thread on the core stalls together.

Once powered, the upper half stays on as long as wide operations keep arriving. An idle threshold is programmed as a number of time units times the cycles in one unit. When that many consecutive cycles pass with no wide operation, the half is powered down. Power-down asserts isolation for a programmable number of cycles before the controller returns to the gated state. A wide operation that arrives during power-down cancels it and goes straight into a full settling stall.

All configuration inputs are captured only while the controller is gated, so software can change them at any time without disturbing a cycle already in progress. Every interval is counted in core cycles, so the behaviour is the same at any clock frequency.

Top module: `vpg_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, pwr_en, emu_mode, core_stall and iso_en are all low and thr_div is 1.
- R2: A wide op in the gated state moves the controller to emulation, where emu_mode is high, pwr_en is low and thr_div reads 4; outside emulation thr_div reads 1.
- R3: Let N be cfg_emu_ops, with any value below 4 treated as 4. The N-th wide op counted from the one that left the gated state ends emulation and starts the settling stall.
- R4: The settling stall lasts exactly cfg_stall_cycles cycles, with 0 treated as 1. During it core_stall and pwr_en are high and emu_mode is low. Wide ops during the stall are ignored, and the controller then enters the on state.
- R5: Every bit of thread_stall equals core_stall in every cycle.
- R6: In the on state pwr_en is high. After T = cfg_idle_units * cfg_cycles_per_unit consecutive op-free cycles (a product of 0 is treated as 1), power-down begins. Any wide op restarts the count.
- R7: Power-down holds iso_en high and pwr_en low for exactly cfg_iso_cycles cycles, with 0 treated as 1, and then returns to the gated state.
- R8: A wide op during power-down leads on the next cycle to a full settling stall of the captured length, followed by the on state.
- R9: Configuration inputs are captured only in the gated state; changes made in any other state have no effect until the controller is gated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_op | input | 1 | Strobe: a wide operation is issued this cycle |
| cfg_emu_ops | input | 3 | Number of emulated wide ops before power-up (4..7) |
| cfg_stall_cycles | input | 16 | Length of the settling stall in cycles |
| cfg_iso_cycles | input | 8 | Length of the power-down isolation window in cycles |
| cfg_idle_units | input | 12 | Idle threshold in time units |
| cfg_cycles_per_unit | input | 16 | Core cycles in one time unit |
| pwr_en | output | 1 | Upper-half power enable |
| emu_mode | output | 1 | Wide ops run in emulation on the lower half |
| core_stall | output | 1 | Whole-core stall during settling |
| thread_stall | output | NTHREADS | Per-thread stall, all equal to core_stall |
| iso_en | output | 1 | Isolation of the discharging upper half |
| thr_div | output | 3 | Throughput-divider hint: 4 in emulation, else 1 |

## Verification
The bench keeps the default widths and two threads, and drives short intervals from the inputs: stalls of 1 to 10 cycles, idle thresholds of 2 to 9 cycles and isolation windows of 1 to 9 cycles. With intervals this short, every full trip through gated, emulation, stall, on and power-down fits in a few dozen cycles. That makes it affordable to sweep every emulation count value, including the clamped ones below 4, and to place zero-valued stall and isolation settings, a power-down abort and mid-cycle configuration changes at exact cycle boundaries.

// File: rtl/vpg_pkg.sv
package vpg_pkg;

  typedef enum logic [2:0] {
    ST_GATED     = 3'd0,
    ST_EMULATE   = 3'd1,
    ST_PWR_UP    = 3'd2,
    ST_ON        = 3'd3,
    ST_PWR_DOWN  = 3'd4
  } vpg_state_e;

  localparam logic [2:0] DIV_EMU  = 3'd4;
  localparam logic [2:0] DIV_FULL = 3'd1;

endpackage

// File: rtl/vpg_cfg_shadow.sv
module vpg_cfg_shadow #(
  parameter int EMU_W    = 3,
  parameter int EMU_MIN  = 4,
  parameter int EMU_DEF  = 6,
  parameter int STALL_W  = 16,
  parameter int ISO_W    = 8,
  parameter int UNITS_W  = 12,
  parameter int UNIT_W   = 16,
  localparam int IDLE_W  = UNITS_W + UNIT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample,
  input  logic [EMU_W-1:0]   cfg_emu_ops,
  input  logic [STALL_W-1:0] cfg_stall_cycles,
  input  logic [ISO_W-1:0]   cfg_iso_cycles,
  input  logic [UNITS_W-1:0] cfg_idle_units,
  input  logic [UNIT_W-1:0]  cfg_cycles_per_unit,
  output logic [EMU_W-1:0]   emu_lim,
  output logic [STALL_W-1:0] stall_len,
  output logic [ISO_W-1:0]   iso_len,
  output logic [IDLE_W-1:0]  idle_thr
);

  logic [IDLE_W-1:0] prod;

  always_comb begin
    prod = IDLE_W'(cfg_idle_units) * IDLE_W'(cfg_cycles_per_unit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      emu_lim   <= EMU_W'(EMU_DEF);
      stall_len <= STALL_W'(1);
      iso_len   <= ISO_W'(1);
      idle_thr  <= IDLE_W'(1);
    end else if (sample) begin
      emu_lim   <= (cfg_emu_ops < EMU_W'(EMU_MIN)) ? EMU_W'(EMU_MIN) : cfg_emu_ops;
      stall_len <= (cfg_stall_cycles == '0) ? STALL_W'(1) : cfg_stall_cycles;
      iso_len   <= (cfg_iso_cycles == '0) ? ISO_W'(1) : cfg_iso_cycles;
      idle_thr  <= (prod == '0) ? IDLE_W'(1) : prod;
    end
  end

endmodule

// File: rtl/vpg_phase_cnt.sv
module vpg_phase_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign last = run && (cnt == W'(1));

endmodule

// File: rtl/vpg_idle_timer.sv
module vpg_idle_timer #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         kick,
  input  logic [W-1:0] thr,
  output logic         expire
);

  logic [W-1:0] cnt;
  logic [W-1:0] cnt_inc;

  assign cnt_inc = cnt + W'(1);
  assign expire  = active && !kick && (cnt_inc == thr);

  always_ff @(posedge clk) begin
    if (rst || !active || kick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_inc;
    end
  end

endmodule

// File: rtl/vpg_ctrl.sv
module vpg_ctrl
  import vpg_pkg::*;
#(
  parameter int NTHREADS = 2,
  parameter int EMU_W    = 3,
  parameter int EMU_MIN  = 4,
  parameter int EMU_DEF  = 6,
  parameter int STALL_W  = 16,
  parameter int ISO_W    = 8,
  parameter int UNITS_W  = 12,
  parameter int UNIT_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_op,
  input  logic [EMU_W-1:0]    cfg_emu_ops,
  input  logic [STALL_W-1:0]  cfg_stall_cycles,
  input  logic [ISO_W-1:0]    cfg_iso_cycles,
  input  logic [UNITS_W-1:0]  cfg_idle_units,
  input  logic [UNIT_W-1:0]   cfg_cycles_per_unit,
  output logic                pwr_en,
  output logic                emu_mode,
  output logic                core_stall,
  output logic [NTHREADS-1:0] thread_stall,
  output logic                iso_en,
  output logic [2:0]          thr_div
);

  localparam int IDLE_W = UNITS_W + UNIT_W;
  localparam int PH_W   = (STALL_W > ISO_W) ? STALL_W : ISO_W;

  vpg_state_e st, nxt;

  logic [EMU_W-1:0]   emu_lim;
  logic [STALL_W-1:0] stall_len;
  logic [ISO_W-1:0]   iso_len;
  logic [IDLE_W-1:0]  idle_thr;
  logic [EMU_W-1:0]   emu_cnt;
  logic [EMU_W:0]     emu_cnt_nx;
  logic               ph_load;
  logic [PH_W-1:0]    ph_val;
  logic               ph_run;
  logic               ph_last;
  logic               idle_expire;

  // Configuration capture: only while gated.
  vpg_cfg_shadow #(
    .EMU_W(EMU_W), .EMU_MIN(EMU_MIN), .EMU_DEF(EMU_DEF),
    .STALL_W(STALL_W), .ISO_W(ISO_W), .UNITS_W(UNITS_W), .UNIT_W(UNIT_W)
  ) u_shadow (
    .clk                 (clk),
    .rst                 (rst),
    .sample              (st == ST_GATED),
    .cfg_emu_ops         (cfg_emu_ops),
    .cfg_stall_cycles    (cfg_stall_cycles),
    .cfg_iso_cycles      (cfg_iso_cycles),
    .cfg_idle_units      (cfg_idle_units),
    .cfg_cycles_per_unit (cfg_cycles_per_unit),
    .emu_lim             (emu_lim),
    .stall_len           (stall_len),
    .iso_len             (iso_len),
    .idle_thr            (idle_thr)
  );

  // One counter times both the settling stall and the isolation window.
  assign ph_run = (st == ST_PWR_UP) || (st == ST_PWR_DOWN);

  vpg_phase_cnt #(.W(PH_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_val),
    .run      (ph_run),
    .last     (ph_last)
  );

  vpg_idle_timer #(.W(IDLE_W)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .active (st == ST_ON),
    .kick   (wide_op),
    .thr    (idle_thr),
    .expire (idle_expire)
  );

  assign emu_cnt_nx = {1'b0, emu_cnt} + (EMU_W+1)'(1);

  always_comb begin
    nxt     = st;
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (st)
      ST_GATED: begin
        if (wide_op) nxt = ST_EMULATE;
      end
      ST_EMULATE: begin
        if (wide_op && emu_cnt_nx == {1'b0, emu_lim}) begin
          nxt     = ST_PWR_UP;
          ph_load = 1'b1;
          ph_val  = PH_W'(stall_len);
        end
      end
      ST_PWR_UP: begin
        if (ph_last) nxt = ST_ON;
      end
      ST_ON: begin
        if (idle_expire) begin
          nxt     = ST_PWR_DOWN;
          ph_load = 1'b1;
          ph_val  = PH_W'(iso_len);
        end
      end
      ST_PWR_DOWN: begin
        if (wide_op) begin
          nxt     = ST_PWR_UP;
          ph_load = 1'b1;
          ph_val  = PH_W'(stall_len);
        end else if (ph_last) begin
          nxt = ST_GATED;
        end
      end
      default: nxt = ST_GATED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_GATED;
      emu_cnt <= '0;
    end else begin
      st <= nxt;
      if (st == ST_GATED && wide_op) begin
        emu_cnt <= EMU_W'(1);
      end else if (st == ST_EMULATE && wide_op) begin
        emu_cnt <= emu_cnt_nx[EMU_W-1:0];
      end
    end
  end

  // Outputs registered from the next state.
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_en       <= 1'b0;
      emu_mode     <= 1'b0;
      core_stall   <= 1'b0;
      thread_stall <= '0;
      iso_en       <= 1'b0;
      thr_div      <= DIV_FULL;
    end else begin
      pwr_en       <= (nxt == ST_PWR_UP) || (nxt == ST_ON);
      emu_mode     <= (nxt == ST_EMULATE);
      core_stall   <= (nxt == ST_PWR_UP);
      thread_stall <= {NTHREADS{nxt == ST_PWR_UP}};
      iso_en       <= (nxt == ST_PWR_DOWN);
      thr_div      <= (nxt == ST_EMULATE) ? DIV_EMU : DIV_FULL;
    end
  end

endmodule

// File: rtl/vpg_ctrl_chk.sv
module vpg_ctrl_chk #(
  parameter int NTHREADS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                wide_op,
  input logic                pwr_en,
  input logic                emu_mode,
  input logic                core_stall,
  input logic [NTHREADS-1:0] thread_stall,
  input logic                iso_en,
  input logic [2:0]          thr_div
);

  // R1: reset quiets every control output on the next cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pwr_en && !emu_mode && !core_stall && !iso_en && thr_div == 3'd1));

  // R1: power only ever rises into a settling stall
  a_r1_power_rises_stalled: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(pwr_en)) |-> core_stall);

  // R2: emulation slows issue by four and keeps the half unpowered
  a_r2_emu_hint: assert property (@(posedge clk) disable iff (rst)
    emu_mode |-> (thr_div == 3'd4 && !pwr_en));

  // R3: emulation only ends in a settling stall
  a_r3_emu_exit_stall: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(emu_mode)) |-> core_stall);

  // R4: stall runs with power on and without emulation
  a_r4_stall_powered: assert property (@(posedge clk) disable iff (rst)
    core_stall |-> (pwr_en && !emu_mode && !iso_en));

  // R5: all threads halt together
  a_r5_threads_together: assert property (@(posedge clk) disable iff (rst)
    thread_stall == {NTHREADS{core_stall}});

  // R7: isolation only while the half is unpowered
  a_r7_iso_unpowered: assert property (@(posedge clk) disable iff (rst)
    iso_en |-> (!pwr_en && !emu_mode));

  // R8: a wide op during power-down leads to a stall
  a_r8_abort_to_stall: assert property (@(posedge clk) disable iff (rst)
    (iso_en && wide_op) |=> core_stall);

  // R2: at most one of the mode flags at a time
  a_r2_modes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({emu_mode, core_stall, iso_en}));

endmodule

bind vpg_ctrl vpg_ctrl_chk #(.NTHREADS(NTHREADS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wide_op      (wide_op),
  .pwr_en       (pwr_en),
  .emu_mode     (emu_mode),
  .core_stall   (core_stall),
  .thread_stall (thread_stall),
  .iso_en       (iso_en),
  .thr_div      (thr_div)
);

// File: tb/tb_vpg_ctrl.sv
module tb_vpg_ctrl;

  localparam int NT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_op = 1'b0;
  logic [2:0]  cfg_emu_ops = 3'd6;
  logic [15:0] cfg_stall_cycles = 16'd4;
  logic [7:0]  cfg_iso_cycles = 8'd3;
  logic [11:0] cfg_idle_units = 12'd2;
  logic [15:0] cfg_cycles_per_unit = 16'd2;
  logic        pwr_en, emu_mode, core_stall, iso_en;
  logic [NT-1:0] thread_stall;
  logic [2:0]  thr_div;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vpg_ctrl #(.NTHREADS(NT)) dut (
    .clk(clk), .rst(rst), .wide_op(wide_op),
    .cfg_emu_ops(cfg_emu_ops), .cfg_stall_cycles(cfg_stall_cycles),
    .cfg_iso_cycles(cfg_iso_cycles), .cfg_idle_units(cfg_idle_units),
    .cfg_cycles_per_unit(cfg_cycles_per_unit),
    .pwr_en(pwr_en), .emu_mode(emu_mode), .core_stall(core_stall),
    .thread_stall(thread_stall), .iso_en(iso_en), .thr_div(thr_div)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Compare outputs with an expected mode: {pwr, emu, stall, iso}.
  task automatic expect_mode(input string req, input logic [3:0] exp);
    logic [3:0] act;
    logic [2:0] div_exp;
    act = {pwr_en, emu_mode, core_stall, iso_en};
    div_exp = exp[2] ? 3'd4 : 3'd1;
    n_chk++;
    if (act !== exp || thr_div !== div_exp || thread_stall !== {NT{exp[1]}}) begin
      n_bad++;
      $display("FAIL %s: mode act=%b exp=%b div act=%0d exp=%0d thr act=%b exp=%b",
               req, act, exp, thr_div, div_exp, thread_stall, {NT{exp[1]}});
    end
  endtask

  localparam logic [3:0] M_GATED = 4'b0000;
  localparam logic [3:0] M_EMU   = 4'b0100;
  localparam logic [3:0] M_STALL = 4'b1010;
  localparam logic [3:0] M_ON    = 4'b1000;
  localparam logic [3:0] M_DOWN  = 4'b0001;

  task automatic step(input logic op);
    wide_op = op;
    @(posedge clk);
    @(negedge clk);
    wide_op = 1'b0;
  endtask

  task automatic run_stall(input int s);
    for (int k = 1; k < s; k++) begin
      step(k[0]);                 // R4: ops during stall are ignored
      expect_mode("R4 stall held", M_STALL);
    end
    step(1'b0);
    expect_mode("R4 stall ends in on", M_ON);
  endtask

  task automatic run_idle(input int t, input bit kick);
    if (kick) begin
      for (int k = 1; k < t; k++) step(1'b0);
      step(1'b1);
      expect_mode("R6 op keeps power", M_ON);
    end
    for (int k = 1; k < t; k++) begin
      step(1'b0);
      expect_mode("R6 still on", M_ON);
    end
    step(1'b0);
    expect_mode("R6 idle power-down", M_DOWN);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step(1'b1);
    expect_mode("R1 in reset", M_GATED);
    step(1'b0);
    rst = 1'b0;
    step(1'b0);
    expect_mode("R1 after reset", M_GATED);

    for (int e = 0; e < 8; e++) begin
      int n, s, s_cfg, t, iso, iso_cfg, units, cpu;
      n     = (e < 4) ? 4 : e;
      s_cfg = (e == 2) ? 0 : 3 + e;
      s     = (s_cfg == 0) ? 1 : s_cfg;
      iso_cfg = (e == 6) ? 0 : 2 + e;
      iso   = (iso_cfg == 0) ? 1 : iso_cfg;
      units = 1 + (e % 3);
      cpu   = 2 + (e % 2);
      t     = units * cpu;
      cfg_emu_ops         = 3'(e);
      cfg_stall_cycles    = 16'(s_cfg);
      cfg_iso_cycles      = 8'(iso_cfg);
      cfg_idle_units      = 12'(units);
      cfg_cycles_per_unit = 16'(cpu);
      step(1'b0);
      expect_mode("R7 gated before ops", M_GATED);

      step(1'b1);
      expect_mode("R2 first op emulates", M_EMU);
      // R9: inputs changed outside gated must not matter
      cfg_emu_ops         = 3'd7;
      cfg_stall_cycles    = 16'd40;
      cfg_iso_cycles      = 8'd30;
      cfg_idle_units      = 12'd9;
      cfg_cycles_per_unit = 16'd9;
      for (int k = 2; k < n; k++) begin
        step(1'b0);
        expect_mode("R3 emulation idles", M_EMU);
        step(1'b1);
        expect_mode("R3 emulation count", M_EMU);
      end
      step(1'b1);
      expect_mode("R3 count reached stalls", M_STALL);
      run_stall(s);
      run_idle(t, e == 5);
      if (e[0]) begin
        step(1'b1);
        expect_mode("R8 abort to stall", M_STALL);
        run_stall(s);
        run_idle(t, 1'b0);
      end
      for (int k = 1; k < iso; k++) begin
        step(1'b0);
        expect_mode("R7 isolation held", M_DOWN);
      end
      step(1'b0);
      expect_mode("R7 back to gated R9", M_GATED);
    end

    summary();
    $finish;
  end

endmodule